// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one global memory access from a 32-thread warp: a byte address per thread and a mask of the threads that take part. It groups the active threads by the aligned region their address falls in. Each group becomes one transaction, so the memory side sees the fewest possible aligned requests rather than one per thread. Each transaction leaves on a valid/ready stream with its aligned base address and the set of threads it serves.

The region size is chosen for each request. Line mode uses 128-byte regions. Sector mode uses 32-byte regions. The transactions are issued one at a time in a fixed order, and a single-cycle completion pulse follows the last one. After that pulse the block can take a new warp request. Cache storage, returned data and write data are handled elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `txn_valid` is 0, `done` is 0 and `req_ready` is 1.
- R2: When `req_sector` was 0 at acceptance, every transaction base has its low 7 address bits at zero. Its mask holds exactly those pending active threads whose address, with the low 7 bits cleared, equals that base.
- R3: When `req_sector` was 1 at acceptance, the grouping of R2 uses 32-byte regions. The base then has its low 5 bits at zero.
- R4: One request produces exactly as many transactions as there are distinct regions among its active threads. For example, 32 consecutive 8-byte words from a 128-aligned base give 2 line transactions, and a 64-byte thread stride gives 16.
- R5: Each transaction is the region of the lowest-numbered active thread that no earlier transaction of the request has covered.
- R6: A thread whose `req_mask` bit is 0 never appears in a transaction mask. Its address causes no transaction.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base` and `txn_mask` hold their values into the next cycle. At most one transaction completes per cycle.
- R8: A request accepted with `req_mask` all zero produces no transaction. `done` is 1 in the cycle right after acceptance.
- R9: `req_ready` is 0 while transactions are pending. `done` is 1 for the cycle right after the final transaction handshake and 0 in the cycle after that, unless a new request intervenes.
- R10: The masks of one request's transactions are non-zero and pairwise disjoint. Together they cover the active mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 1024 | Per-thread byte addresses, thread i in bits [32i+31:32i] |
| req_mask | input | 32 | Active threads, bit i for thread i |
| req_sector | input | 1 | 1 selects 32-byte regions, 0 selects 128-byte regions |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | 32 | Region-aligned base address |
| txn_mask | output | 32 | Threads served by this transaction |
| done | output | 1 | One-cycle pulse when the request is fully issued |

## Verification
The assertions assume that the consumer may hold `txn_ready` low for any number of cycles but does not drop a transaction. They also assume that a request is offered only while `req_ready` is high. The stimulus raises `req_valid` only after it has seen `req_ready` high, and it holds the request for exactly one accepting edge. It varies the backpressure density from light to heavy. Random addresses are drawn from a few nearby lines so that merging happens often, and the inactive threads are given unrelated addresses.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {
    WC_IDLE = 1'b0,
    WC_BUSY = 1'b1
  } wc_state_e;
endpackage

// File: rtl/wc_rst_sync.sv
module wc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wc_leader.sv
module wc_leader #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wc_match.sv
module wc_match #(
  parameter int N            = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*ADDR_W-1:0] addrs,
  input  logic [N-1:0]        pending,
  input  logic                sector,
  input  logic [IDX_W-1:0]    leader,
  output logic [ADDR_W-1:0]   base,
  output logic [N-1:0]        match
);
  localparam logic [ADDR_W-1:0] LINE_KEEP = ~(ADDR_W'(LINE_BYTES) - 1'b1);
  localparam logic [ADDR_W-1:0] SEC_KEEP  = ~(ADDR_W'(SECTOR_BYTES) - 1'b1);

  logic [ADDR_W-1:0] aligned [N];

  assign base = aligned[leader];

  for (genvar g = 0; g < N; g++) begin : g_thr
    logic [ADDR_W-1:0] a;
    assign a          = addrs[g*ADDR_W +: ADDR_W];
    assign aligned[g] = a & (sector ? SEC_KEEP : LINE_KEEP);
    assign match[g]   = pending[g] && (aligned[g] == base);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int NUM_THREADS  = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [NUM_THREADS*ADDR_W-1:0] req_addr,
  input  logic [NUM_THREADS-1:0]        req_mask,
  input  logic                          req_sector,
  output logic                          txn_valid,
  input  logic                          txn_ready,
  output logic [ADDR_W-1:0]             txn_base,
  output logic [NUM_THREADS-1:0]        txn_mask,
  output logic                          done
);
  import wc_pkg::*;
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  logic                          rst_sync_n;
  wc_state_e                     state_q, state_d;
  logic [NUM_THREADS*ADDR_W-1:0] addr_q;
  logic [NUM_THREADS-1:0]        pending_q, pending_d, active_q;
  logic                          mode_q, done_q, done_d;
  logic [IDX_W-1:0]              leader;
  logic [NUM_THREADS-1:0]        match;
  logic                          accept, fire, load_en, pend_en;

  wc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  wc_leader #(.N(NUM_THREADS)) u_lead (.vec(pending_q), .idx(leader));

  wc_match #(
    .N(NUM_THREADS), .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_match (
    .addrs(addr_q), .pending(pending_q), .sector(mode_q),
    .leader(leader), .base(txn_base), .match(match)
  );

  assign req_ready = (state_q == WC_IDLE);
  assign txn_valid = (state_q == WC_BUSY);
  assign txn_mask  = match;
  assign done      = done_q;
  assign accept    = req_valid && req_ready;
  assign fire      = txn_valid && txn_ready;
  assign load_en   = accept;
  assign pend_en   = accept || fire;

  always_comb begin
    state_d   = state_q;
    pending_d = pending_q;
    done_d    = 1'b0;
    if (accept) begin
      pending_d = req_mask;
      if (req_mask == '0) done_d = 1'b1;
      else                state_d = WC_BUSY;
    end else if (fire) begin
      pending_d = pending_q & ~match;
      if ((pending_q & ~match) == '0) begin
        state_d = WC_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= WC_IDLE;
      pending_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (pend_en) pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q   <= req_addr;
      active_q <= req_mask;
      mode_q   <= req_sector;
    end
  end
endmodule

// File: rtl/wc_chk.sv
module wc_chk #(
  parameter int N            = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_base,
  input logic [N-1:0]      txn_mask,
  input logic              done,
  input logic [N-1:0]      active_q,
  input logic              mode_q
);
  localparam logic [ADDR_W-1:0] LINE_LOW = ADDR_W'(LINE_BYTES) - 1'b1;
  localparam logic [ADDR_W-1:0] SEC_LOW  = ADDR_W'(SECTOR_BYTES) - 1'b1;

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_mask)));

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !mode_q) |-> ((txn_base & LINE_LOW) == '0));

  // R3
  sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && mode_q) |-> ((txn_base & SEC_LOW) == '0));

  // R10
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask != '0));

  // R6
  inactive_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~active_q) == '0));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid);
endmodule

bind warp_coalescer wc_chk #(
  .N(NUM_THREADS), .ADDR_W(ADDR_W),
  .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_base(txn_base), .txn_mask(txn_mask), .done(done),
  .active_q(active_q), .mode_q(mode_q)
);

// File: tb/warp_coalescer_tb.sv
`timescale 1ns/1ps
module warp_coalescer_tb;
  localparam int N = 32;
  localparam int AW = 32;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_sector;
  logic [N*AW-1:0] req_addr;
  logic [N-1:0]  req_mask;
  logic          txn_valid, txn_ready, done;
  logic [AW-1:0] txn_base;
  logic [N-1:0]  txn_mask;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [AW-1:0] t_addr [N];
  logic [AW-1:0] exp_base [N];
  logic [N-1:0]  exp_mask [N];
  int            exp_n;

  warp_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_sector(req_sector),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
    .txn_mask(txn_mask), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [N-1:0] m, input logic sm);
    logic [N-1:0]  pend;
    logic [AW-1:0] keep, b;
    int            ld;
    keep  = sm ? ~32'd31 : ~32'd127;
    pend  = m;
    exp_n = 0;
    while (pend != '0) begin
      ld = 0;
      for (int i = N - 1; i >= 0; i--) if (pend[i]) ld = i;
      b = t_addr[ld] & keep;
      exp_base[exp_n] = b;
      exp_mask[exp_n] = '0;
      for (int i = 0; i < N; i++)
        if (pend[i] && ((t_addr[i] & keep) == b)) exp_mask[exp_n][i] = 1'b1;
      pend = pend & ~exp_mask[exp_n];
      exp_n++;
    end
  endtask

  task automatic run_req(input logic [N-1:0] m, input logic sm, input string tag,
                         input int ready_pct, input int want_n);
    int got, waitc;
    bit stall;
    logic [AW-1:0] lb;
    logic [N-1:0]  lm;
    model(m, sm);
    if (want_n >= 0) check(exp_n == want_n, "R4 model count", 64'(exp_n), 64'(want_n));
    @(negedge clk);
    check(req_ready == 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
    req_valid  = 1'b1;
    req_mask   = m;
    req_sector = sm;
    for (int i = 0; i < N; i++) req_addr[i*AW +: AW] = t_addr[i];
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_n == 0) begin
      check(done == 1'b1 && txn_valid == 1'b0, "R8 empty request done",
            64'({done, txn_valid}), 64'b10);
      @(negedge clk);
      check(done == 1'b0, "R8 done single", 64'(done), 64'd0);
      return;
    end
    got = 0; waitc = 0; stall = 0; lb = '0; lm = '0;
    while (got < exp_n && waitc < 4000) begin
      txn_ready = (($urandom % 100) < ready_pct);
      check(txn_valid == 1'b1, "R7 valid held while pending", 64'(txn_valid), 64'd1);
      if (stall)
        check(txn_base == lb && txn_mask == lm, "R7 stable under stall",
              {txn_base, txn_mask}, {lb, lm});
      check(req_ready == 1'b0 && done == 1'b0, "R9 busy", 64'({req_ready, done}), 64'd0);
      if (txn_valid && txn_ready) begin
        check(txn_base == exp_base[got], {tag, " base (R2/R3/R5)"}, 64'(txn_base), 64'(exp_base[got]));
        check(txn_mask == exp_mask[got], {tag, " mask (R5/R6/R10)"}, 64'(txn_mask), 64'(exp_mask[got]));
        got++;
      end
      stall = txn_valid && !txn_ready;
      lb = txn_base; lm = txn_mask;
      @(negedge clk);
      waitc++;
    end
    txn_ready = 1'b0;
    check(got == exp_n, "R4 transaction count", 64'(got), 64'(exp_n));
    check(done == 1'b1 && txn_valid == 1'b0, "R9 done after last, R4 no extra",
          64'({done, txn_valid}), 64'b10);
    @(negedge clk);
    check(done == 1'b0, "R9 done pulse ends", 64'(done), 64'd0);
  endtask

  initial begin
    logic [AW-1:0] lines [3];
    logic [N-1:0]  m;
    rst_n = 1'b0; req_valid = 1'b0; txn_ready = 1'b0; req_sector = 1'b0;
    req_mask = '0; req_addr = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(txn_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1 in reset",
          64'({txn_valid, done, req_ready}), 64'b001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txn_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1 after reset",
          64'({txn_valid, done, req_ready}), 64'b001);

    // R4: consecutive 8-byte words from an aligned base -> 2 lines
    for (int i = 0; i < N; i++) t_addr[i] = 32'h0000_1000 + 32'(i * 8);
    run_req('1, 1'b0, "R4 unit-stride", 100, 2);
    // R4: 64-byte stride -> 16 lines, with backpressure (R7)
    for (int i = 0; i < N; i++) t_addr[i] = 32'h0002_0000 + 32'(i * 64);
    run_req('1, 1'b0, "R4 stride64", 40, 16);
    // R8: empty mask
    run_req('0, 1'b0, "R8 empty", 100, 0);
    // R2: all threads same address -> 1 line
    for (int i = 0; i < N; i++) t_addr[i] = 32'h0000_0ABC;
    run_req('1, 1'b0, "R2 broadcast", 100, 1);
    // R3: 4-byte words in sector mode -> 4 sectors
    for (int i = 0; i < N; i++) t_addr[i] = 32'h0000_4000 + 32'(i * 4);
    run_req('1, 1'b1, "R3 sector", 70, 4);
    // R5: descending addresses, order follows thread index
    for (int i = 0; i < N; i++) t_addr[i] = 32'h0010_0000 - 32'(i * 128);
    run_req('1, 1'b0, "R5 descending", 60, 32);
    // R6: inactive threads point at unrelated lines
    for (int i = 0; i < N; i++)
      t_addr[i] = (i % 4 == 0) ? 32'h0000_8010 : 32'hF000_0000 + 32'(i * 4096);
    run_req(32'h1111_1111, 1'b0, "R6 sparse", 50, 1);

    // Random requests (R2 R3 R5 R6 R7 R10)
    for (int r = 0; r < 60; r++) begin
      for (int k = 0; k < 3; k++) lines[k] = ($urandom & 32'hFFFF_FF80) + 32'(k * 128);
      for (int i = 0; i < N; i++) t_addr[i] = lines[$urandom % 3] + ($urandom % 128);
      m = $urandom;
      if (r % 7 == 0) m = m & $urandom;
      run_req(m, 1'($urandom % 2), "R10 random", 20 + int'($urandom % 81), -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule